// File: doc/BRIEF.md
# Settle-Qualified Wide Bus Clock Crossing

This block moves a wide result value from a fast source clock domain into a slower destination clock domain. The source side keeps the value in its own register, loaded by a one-cycle write strobe. In the destination domain every bit of that register passes through two flip-flops. A wide comparator checks the first stage against the second. Bits of one bus can land one destination cycle apart, so the data counts as usable only in a cycle where the two stages agree on every bit.

When the stages agree, the block raises a registered valid flag and copies the second stage into a holding register. Reads always come from this held copy, so a source change that is still crossing never produces a mix of old and new bits. A word index selects one 32-bit slice of the 128-bit held copy. A one-cycle update pulse marks each capture of a settled value that differs from the one already held.

The read side is not a stream. A read does not consume anything, so there is no back-pressure. The selected word is valid in the same cycle the index is applied. The source must keep its register unchanged for at least four destination cycles after each write, so that the compare can succeed.

Top module: `bus_settle_cdc`

## Requirements
- R1: A source write (`src_wr` high at a rising `src_clk` edge) loads `src_data` into the source register. The new value can be read on the destination side within 5 destination cycles after that edge.
- R2: While the two synchronizer stages disagree on any bit, `dst_valid` goes low on the next destination edge. When a written value differs from the one held, `dst_valid` is seen low at least once before the new value is read. Once the stages agree, `dst_valid` returns high.
- R3: The held copy changes only in a cycle where `dst_valid` is high. Each read returns either the complete old value or the complete new value, never a mix of bits. After a new value first appears on a read, it stays there.
- R4: `dst_word` shows bits [32k+31:32k] of the held copy when `dst_word_sel` = k (k = 0..3). It changes in the same cycle as the index.
- R5: `dst_update` is high for exactly one destination cycle each time a settled value that differs from the held copy is captured. Writing the value that is already held produces no pulse.
- R6: While `dst_rst` is high, the next destination edge leaves `dst_valid` low, `dst_update` low and the held copy at zero. While `src_rst` is high, the source register clears to zero.
- R7: When `src_wr` is low, changes on `src_data` have no effect on the held copy or on `dst_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source synchronous reset, active high |
| src_wr | input | 1 | Load strobe for the source register |
| src_data | input | 128 | Value to load |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination synchronous reset, active high |
| dst_word_sel | input | 2 | Index of the 32-bit word to read |
| dst_word | output | 32 | Selected word of the held copy |
| dst_valid | output | 1 | Synchronizer stages agreed in the previous cycle |
| dst_update | output | 1 | One-cycle pulse when a new, different value is captured |

## Verification
A new source value passes the first stage on the first destination edge after the source register loads, and the second stage on the next edge. On the third edge `dst_valid` rises, the held copy loads and `dst_update` pulses. The source and destination clocks have no fixed phase, so the bench does not expect any one edge. Instead it watches every destination cycle in a seven-cycle window after each write: a read must match either the old word or the new word, and `dst_valid` must dip when the value changes. It then checks every word, the valid flag and the update pulse count once the window has closed. Changes to the word index are sampled one time step after they are applied, away from any clock edge.

// File: rtl/bus_settle_pkg.sv
package bus_settle_pkg;
  parameter int unsigned BUS_W  = 128;
  parameter int unsigned WORD_W = 32;
  localparam int unsigned NUM_WORDS = BUS_W / WORD_W;
  localparam int unsigned SEL_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
endpackage

// File: rtl/src_hold_reg.sv
module src_hold_reg #(
  parameter int unsigned W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/bit_sync_pair.sv
module bit_sync_pair #(
  parameter int unsigned W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] stage_a,
  output logic [W-1:0] stage_b
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic ff_a, ff_b;
    always_ff @(posedge clk) begin
      if (rst) begin
        ff_a <= 1'b0;
        ff_b <= 1'b0;
      end else begin
        ff_a <= async_in[b];
        ff_b <= ff_a;
      end
    end
    assign stage_a[b] = ff_a;
    assign stage_b[b] = ff_b;
  end
endmodule

// File: rtl/settle_capture.sv
module settle_capture #(
  parameter int unsigned W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stage_a,
  input  logic [W-1:0] stage_b,
  output logic         valid_q,
  output logic         update_q,
  output logic [W-1:0] held_q
);
  logic same;
  logic fresh;

  assign same  = (stage_a == stage_b);
  assign fresh = (stage_b != held_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      update_q <= 1'b0;
      held_q   <= '0;
    end else begin
      valid_q  <= same;
      update_q <= same && fresh;
      if (same) held_q <= stage_b;
    end
  end
endmodule

// File: rtl/word_pick.sv
module word_pick #(
  parameter int unsigned W      = 128,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned SEL_W  = 2
) (
  input  logic [W-1:0]      data,
  input  logic [SEL_W-1:0]  sel,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned N = W / WORD_W;
  logic [N-1:0][WORD_W-1:0] slices;

  for (genvar k = 0; k < N; k++) begin : g_slice
    assign slices[k] = data[k*WORD_W +: WORD_W];
  end

  always_comb begin
    word = '0;
    for (int k = 0; k < N; k++) begin
      if (sel == SEL_W'(k)) word = slices[k];
    end
  end
endmodule

// File: rtl/bus_settle_cdc.sv
module bus_settle_cdc
  import bus_settle_pkg::*;
#(
  parameter int unsigned P_BUS_W  = BUS_W,
  parameter int unsigned P_WORD_W = WORD_W,
  localparam int unsigned P_SEL_W = (P_BUS_W / P_WORD_W > 1) ? $clog2(P_BUS_W / P_WORD_W) : 1
) (
  input  logic                src_clk,
  input  logic                src_rst,
  input  logic                src_wr,
  input  logic [P_BUS_W-1:0]  src_data,
  input  logic                dst_clk,
  input  logic                dst_rst,
  input  logic [P_SEL_W-1:0]  dst_word_sel,
  output logic [P_WORD_W-1:0] dst_word,
  output logic                dst_valid,
  output logic                dst_update
);
  logic [P_BUS_W-1:0] src_q;
  logic [P_BUS_W-1:0] stage_a;
  logic [P_BUS_W-1:0] stage_b;
  logic [P_BUS_W-1:0] held_q;

  src_hold_reg #(.W(P_BUS_W)) u_src (
    .clk(src_clk), .rst(src_rst), .load(src_wr), .din(src_data), .q(src_q)
  );

  bit_sync_pair #(.W(P_BUS_W)) u_sync (
    .clk(dst_clk), .rst(dst_rst), .async_in(src_q),
    .stage_a(stage_a), .stage_b(stage_b)
  );

  settle_capture #(.W(P_BUS_W)) u_cap (
    .clk(dst_clk), .rst(dst_rst), .stage_a(stage_a), .stage_b(stage_b),
    .valid_q(dst_valid), .update_q(dst_update), .held_q(held_q)
  );

  word_pick #(.W(P_BUS_W), .WORD_W(P_WORD_W), .SEL_W(P_SEL_W)) u_pick (
    .data(held_q), .sel(dst_word_sel), .word(dst_word)
  );
endmodule

// File: rtl/bus_settle_cdc_chk.sv
module bus_settle_cdc_chk #(
  parameter int unsigned W = 128
) (
  input logic         dst_clk,
  input logic         dst_rst,
  input logic         dst_valid,
  input logic         dst_update,
  input logic [W-1:0] stage_a,
  input logic [W-1:0] stage_b,
  input logic [W-1:0] held_q
);
  AST_RESET_CLEARS: assert property (@(posedge dst_clk)
    dst_rst |=> (!dst_valid && !dst_update && held_q == '0)); // R6
  AST_DISAGREE_DROPS_VALID: assert property (@(posedge dst_clk) disable iff (dst_rst)
    (stage_a != stage_b) |=> !dst_valid); // R2
  AST_VALID_HELD_MATCH: assert property (@(posedge dst_clk) disable iff (dst_rst)
    dst_valid |-> (stage_b == held_q)); // R3
  AST_HELD_MOVES_ONLY_VALID: assert property (@(posedge dst_clk) disable iff (dst_rst)
    !$stable(held_q) |-> dst_valid); // R3
  AST_UPDATE_ONE_CYCLE: assert property (@(posedge dst_clk) disable iff (dst_rst)
    dst_update |=> !dst_update); // R5
  AST_UPDATE_NEW_VALUE: assert property (@(posedge dst_clk) disable iff (dst_rst)
    dst_update |-> (dst_valid && held_q != $past(held_q))); // R5
endmodule

bind bus_settle_cdc bus_settle_cdc_chk #(.W(P_BUS_W)) u_chk (
  .dst_clk(dst_clk), .dst_rst(dst_rst), .dst_valid(dst_valid),
  .dst_update(dst_update), .stage_a(stage_a), .stage_b(stage_b), .held_q(held_q)
);

// File: tb/test_bus_settle_cdc.sv
module test_bus_settle_cdc;
  logic         src_clk = 1'b0, dst_clk = 1'b0;
  logic         src_rst = 1'b1, dst_rst = 1'b1;
  logic         src_wr = 1'b0;
  logic [127:0] src_data = '0;
  logic [1:0]   dst_word_sel = 2'd0;
  logic [31:0]  dst_word;
  logic         dst_valid, dst_update;

  int vectors = 0, errors = 0, upd_cnt = 0;
  logic [127:0] model = '0;

  bus_settle_cdc i_bus_settle_cdc (
    .src_clk(src_clk), .src_rst(src_rst), .src_wr(src_wr), .src_data(src_data),
    .dst_clk(dst_clk), .dst_rst(dst_rst), .dst_word_sel(dst_word_sel),
    .dst_word(dst_word), .dst_valid(dst_valid), .dst_update(dst_update)
  );

  always #5 dst_clk = ~dst_clk;
  initial begin #1; forever #2 src_clk = ~src_clk; end

  always @(posedge dst_clk) if (!dst_rst && dst_update) upd_cnt++;

  function automatic logic [31:0] word_of(logic [127:0] v, int k);
    return v[k*32 +: 32];
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all_words(logic [127:0] exp, string req);
    for (int k = 0; k < 4; k++) begin
      @(negedge dst_clk);
      dst_word_sel = 2'(k);
      #1;
      check(dst_word == word_of(exp, k), req, 128'(dst_word), 128'(word_of(exp, k)));
    end
  endtask

  // write, then watch a 7-cycle window for torn reads and a valid dip
  task automatic write_and_watch(logic [127:0] v);
    logic [127:0] old = model;
    int k = int'($urandom_range(0, 3));
    bit dipped = 1'b0, seen_new = 1'b0, torn = 1'b0, back = 1'b0;
    int start_upd;
    @(negedge dst_clk);
    dst_word_sel = 2'(k);
    start_upd = upd_cnt;
    @(negedge src_clk);
    src_data = v; src_wr = 1'b1;
    @(negedge src_clk);
    src_wr = 1'b0;
    for (int c = 0; c < 7; c++) begin
      @(negedge dst_clk);
      if (!dst_valid) dipped = 1'b1;
      if (dst_word != word_of(old, k) && dst_word != word_of(v, k)) torn = 1'b1;
      if (seen_new && dst_word != word_of(v, k)) back = 1'b1;
      if (dst_word == word_of(v, k)) seen_new = 1'b1;
    end
    model = v;
    check(!torn && !back, "R3 read torn or reverted", 128'(dst_word), 128'(word_of(v, k)));
    if (old != v)
      check(dipped, "R2 valid dip on change", 128'(dipped), 128'(1));
    check(dst_valid, "R2 valid after settle", 128'(dst_valid), 128'(1));
    check(upd_cnt - start_upd == ((old != v) ? 1 : 0), "R5 update pulse count",
          128'(upd_cnt - start_upd), 128'((old != v) ? 1 : 0));
    check_all_words(v, "R1 R4 word readout");
  endtask

  initial begin
    repeat (100000) @(posedge dst_clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c3d_77a1));
    repeat (4) @(posedge dst_clk);
    @(negedge dst_clk);
    src_rst = 1'b0; dst_rst = 1'b0;
    #1;
    // R6 reset state
    check(!dst_valid && !dst_update, "R6 reset flags", {dst_valid, dst_update}, '0);
    check_all_words('0, "R6 held copy zero after reset");

    // R4 directed word mapping
    write_and_watch({32'hDDDD_0003, 32'hCCCC_0002, 32'hBBBB_0001, 32'hAAAA_0000});
    // R5 same value again: no pulse
    write_and_watch(model);

    // R7 src_data moves without a write
    for (int c = 0; c < 6; c++) begin
      @(negedge src_clk);
      src_data = {$urandom, $urandom, $urandom, $urandom};
    end
    repeat (6) @(negedge dst_clk);
    check_all_words(model, "R7 data ignored without write");

    // corner values
    write_and_watch('1);
    write_and_watch('0);
    write_and_watch(128'h8000_0000_0000_0000_0000_0000_0000_0001);

    for (int n = 0; n < 30; n++)
      write_and_watch({$urandom, $urandom, $urandom, $urandom});

    // R6 source reset clears source register, seen at the read side
    @(negedge src_clk); src_rst = 1'b1;
    @(negedge src_clk); src_rst = 1'b0;
    repeat (7) @(negedge dst_clk);
    model = '0;
    check_all_words('0, "R6 source reset propagates zero");

    // R6 destination reset clears held copy
    write_and_watch({4{32'h5A5A_A5A5}});
    @(negedge dst_clk); dst_rst = 1'b1;
    @(negedge dst_clk);
    check(!dst_valid && !dst_update, "R6 flags in reset", {dst_valid, dst_update}, '0);
    check_all_words('0, "R6 held cleared by reset");
    dst_rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule